// File: doc/BRIEF.md
# Ganged Output Pin Override Controller

This block is the output multiplexer of a small sixteen-pin general-purpose I/O bank, made of two eight-bit ports. Some pins may be wired together on the board to deliver more current than one driver can give. Software picks those pins through an eight-bit configuration register, and the block then makes every chosen pin copy one master pin. Each copy becomes an output and takes its data, drive-strength and slew-rate values from the master pin's port registers.

The configuration register can be written only once after each reset. Bit 0 switches the gang on. Bits 1 to 7 each add one fixed pin to the gang. For every pin the block resolves four outputs (output enable, data, drive strength, slew rate), using a fixed order of precedence: an analog function comes first, then the gang, then a digital peripheral, then the plain port registers. The pin outputs are purely combinational. The only storage is the configuration register and its written flag.

Top module: `gang_drive_top`

## Requirements
- R1: After reset the configuration register reads back as 0x00 and no pin is in the gang.
- R2: The first write strobe after reset loads all eight bits of `cfg_wdata`, and the new value reads back from the next clock cycle.
- R3: Every write strobe after the first is ignored until the next reset, and the read value stays unchanged. A reset allows one write again.
- R4: When bit 0 of the register is 0, each pin is a plain port pin whatever bits 7:1 hold: output enable from its direction bit, and data, drive and slew from its own registers (unless R9 or R10 applies).
- R5: When bit 0 is 1, the master pin (index 0, port C pin 0) is an output even if its direction bit is 0. It drives its own data, drive and slew values.
- R6: Pin index i below 8 is port C pin i, and index 8+j is port B pin j. Select bits 1, 2 and 3 add indices 1, 2 and 3. Select bits 4, 5, 6 and 7 add indices 10, 11, 12 and 13 (port B pins 2, 3, 4 and 5).
- R7: A pin in the gang has output enable 1 and drives the master pin's port data, drive and slew bits in place of its own.
- R8: On a pin in the gang, a peripheral request (`periph_en`=1) has no effect on any of the four outputs.
- R9: A pin with `analog_en`=1 drives all four outputs to 0, even when it is in the gang or requested by a peripheral.
- R10: A pin outside the gang with `periph_en`=1 takes output enable and data from `periph_oe` and `periph_dout`, and drive and slew from its own port registers.
- R11: While the gang is on, pins that are not selected keep their normal port or peripheral behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Write data (bit 0 enable, bits 7:1 pin selects) |
| cfg_rdata | output | 8 | Current register value |
| port_dir | input | 16 | Per-pin direction bits (1 = output) |
| port_dout | input | 16 | Per-pin port data bits |
| port_drv | input | 16 | Per-pin drive-strength bits |
| port_slew | input | 16 | Per-pin slew-rate bits |
| periph_en | input | 16 | Per-pin digital peripheral ownership request |
| periph_oe | input | 16 | Peripheral output enable |
| periph_dout | input | 16 | Peripheral data |
| analog_en | input | 16 | Per-pin analog function enable |
| pad_oe | output | 16 | Resolved output enable |
| pad_do | output | 16 | Resolved output data |
| pad_drv | output | 16 | Resolved drive strength |
| pad_slew | output | 16 | Resolved slew rate |

## Verification
The bench runs all 256 register values through a fresh reset and a single write. This catches a select bit wired to the wrong pin, a gang that stays active while bit 0 is clear, and a master that follows its own direction bit. Vectors in which analog, peripheral and gang requests fall on the same pins expose a priority order that is swapped, which would let a peripheral drive a gang member or let the gang drive a pin in analog use. Directed tests write twice and then reset and write again. A flag that never locks changes the read-back value, and a flag that reset does not clear refuses the second legal write.

// File: rtl/gang_pkg.sv
package gang_pkg;
  localparam int CFG_W    = 8;
  localparam int PORT_W   = 8;
  localparam int NPINS    = 2 * PORT_W;
  localparam int NSEL     = CFG_W - 1;
  localparam int MASTER   = 0;
  localparam int PC_SELS  = 3;
  localparam int PB_FIRST = 2;

  typedef enum logic [1:0] {
    SRC_PORT   = 2'd0,
    SRC_PERIPH = 2'd1,
    SRC_GANG   = 2'd2,
    SRC_ANALOG = 2'd3
  } pin_src_e;

  // pin index joined by select bit k (1..NSEL)
  function automatic int sel_to_pin(input int k);
    if (k <= PC_SELS) return k;
    return PORT_W + PB_FIRST + (k - PC_SELS - 1);
  endfunction
endpackage

// File: rtl/gang_cfg_reg.sv
module gang_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         written
);
  logic take;
  assign take = wr && !written;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= '0;
      written <= 1'b0;
    end else if (take) begin
      q       <= wdata;
      written <= 1'b1;
    end
  end
endmodule

// File: rtl/gang_member_map.sv
module gang_member_map
  import gang_pkg::*;
#(
  parameter int NP = NPINS,
  parameter int NS = NSEL
) (
  input  logic [NS:0]   cfg,
  output logic [NP-1:0] member
);
  always_comb begin
    member = '0;
    if (cfg[0]) begin
      member[MASTER] = 1'b1;
      for (int k = 1; k <= NS; k++) begin
        if (cfg[k]) member[sel_to_pin(k)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gang_pin_cell.sv
module gang_pin_cell
  import gang_pkg::*;
(
  input  logic member,
  input  logic analog,
  input  logic p_en,
  input  logic p_oe,
  input  logic p_do,
  input  logic dir,
  input  logic dout,
  input  logic drv,
  input  logic slew,
  input  logic m_dout,
  input  logic m_drv,
  input  logic m_slew,
  output logic oe,
  output logic dq,
  output logic ds,
  output logic sr
);
  pin_src_e src;

  always_comb begin
    if (analog)      src = SRC_ANALOG;
    else if (member) src = SRC_GANG;
    else if (p_en)   src = SRC_PERIPH;
    else             src = SRC_PORT;
  end

  always_comb begin
    unique case (src)
      SRC_ANALOG: begin oe = 1'b0; dq = 1'b0;   ds = 1'b0;  sr = 1'b0;   end
      SRC_GANG:   begin oe = 1'b1; dq = m_dout; ds = m_drv; sr = m_slew; end
      SRC_PERIPH: begin oe = p_oe; dq = p_do;   ds = drv;   sr = slew;   end
      default:    begin oe = dir;  dq = dout;   ds = drv;   sr = slew;   end
    endcase
  end
endmodule

// File: rtl/gang_drive_top.sv
module gang_drive_top
  import gang_pkg::*;
#(
  parameter int CW = CFG_W,
  parameter int NP = NPINS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] cfg_rdata,
  input  logic [NP-1:0] port_dir,
  input  logic [NP-1:0] port_dout,
  input  logic [NP-1:0] port_drv,
  input  logic [NP-1:0] port_slew,
  input  logic [NP-1:0] periph_en,
  input  logic [NP-1:0] periph_oe,
  input  logic [NP-1:0] periph_dout,
  input  logic [NP-1:0] analog_en,
  output logic [NP-1:0] pad_oe,
  output logic [NP-1:0] pad_do,
  output logic [NP-1:0] pad_drv,
  output logic [NP-1:0] pad_slew
);
  logic          cfg_written;
  logic [NP-1:0] gang_member;

  gang_cfg_reg #(.W(CW)) cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .wdata   (cfg_wdata),
    .q       (cfg_rdata),
    .written (cfg_written)
  );

  gang_member_map #(.NP(NP), .NS(CW-1)) map_i (
    .cfg    (cfg_rdata),
    .member (gang_member)
  );

  for (genvar i = 0; i < NP; i++) begin : g_pin
    gang_pin_cell cell_i (
      .member (gang_member[i]),
      .analog (analog_en[i]),
      .p_en   (periph_en[i]),
      .p_oe   (periph_oe[i]),
      .p_do   (periph_dout[i]),
      .dir    (port_dir[i]),
      .dout   (port_dout[i]),
      .drv    (port_drv[i]),
      .slew   (port_slew[i]),
      .m_dout (port_dout[MASTER]),
      .m_drv  (port_drv[MASTER]),
      .m_slew (port_slew[MASTER]),
      .oe     (pad_oe[i]),
      .dq     (pad_do[i]),
      .ds     (pad_drv[i]),
      .sr     (pad_slew[i])
    );
  end
endmodule

// File: rtl/gang_drive_chk.sv
module gang_drive_chk
  import gang_pkg::*;
#(
  parameter int CW = CFG_W,
  parameter int NP = NPINS
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [CW-1:0] cfg_wdata,
  input logic [CW-1:0] cfg_rdata,
  input logic          cfg_written,
  input logic [NP-1:0] gang_member,
  input logic [NP-1:0] port_dout,
  input logic [NP-1:0] port_dir,
  input logic [NP-1:0] analog_en,
  input logic [NP-1:0] pad_oe,
  input logic [NP-1:0] pad_do
);
  logic [NP-1:0] live_gang;
  assign live_gang = gang_member & ~analog_en;

  // R2
  first_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_written) |=> (cfg_rdata == $past(cfg_wdata)));

  // R3
  later_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_written |=> $stable(cfg_rdata));

  // R4
  disabled_no_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[0] |-> (gang_member == '0));

  // R5
  master_forced_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[0] && !analog_en[MASTER] && !port_dir[MASTER]) |-> pad_oe[MASTER]);

  // R7
  member_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((live_gang & ~pad_oe) == '0) &&
    ((live_gang & (pad_do ^ {NP{port_dout[MASTER]}})) == '0));

  // R9
  analog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((analog_en & (pad_oe | pad_do)) == '0));
endmodule

bind gang_drive_top gang_drive_chk #(.CW(CW), .NP(NP)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .cfg_wdata   (cfg_wdata),
  .cfg_rdata   (cfg_rdata),
  .cfg_written (cfg_written),
  .gang_member (gang_member),
  .port_dout   (port_dout),
  .port_dir    (port_dir),
  .analog_en   (analog_en),
  .pad_oe      (pad_oe),
  .pad_do      (pad_do)
);

// File: tb/gang_drive_top_tb.sv
module gang_drive_top_tb_top;
  typedef struct packed {
    logic [7:0]  cfg;
    logic [15:0] dir;
    logic [15:0] dout;
    logic [15:0] drv;
    logic [15:0] slew;
    logic [15:0] pen;
    logic [15:0] poe;
    logic [15:0] pdo;
    logic [15:0] ana;
  } vec_t;

  // cfg, dir, dout, drv, slew, pen, poe, pdo, ana
  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 16'h0F0F, 16'h5555, 16'h3333, 16'h00FF, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, // R4
    '{8'hFE, 16'hFFFF, 16'hA5A5, 16'hF0F0, 16'h0F0F, 16'h3C00, 16'hFFFF, 16'h0000, 16'h0000}, // R4 R10
    '{8'h01, 16'h0000, 16'h0001, 16'h0001, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, // R5
    '{8'hFF, 16'h0000, 16'hFFFE, 16'hFFFE, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, // R7
    '{8'hFF, 16'h0000, 16'h0001, 16'h0000, 16'h0001, 16'h3C0E, 16'h0000, 16'hFFFF, 16'h0000}, // R8
    '{8'h93, 16'hC000, 16'h8001, 16'h0001, 16'h0000, 16'h4004, 16'h4004, 16'h4004, 16'h1002}  // R9 R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] port_dir = '0, port_dout = '0, port_drv = '0, port_slew = '0;
  logic [15:0] periph_en = '0, periph_oe = '0, periph_dout = '0, analog_en = '0;
  logic [15:0] pad_oe, pad_do, pad_drv, pad_slew;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gang_drive_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .port_dir(port_dir), .port_dout(port_dout),
    .port_drv(port_drv), .port_slew(port_slew), .periph_en(periph_en),
    .periph_oe(periph_oe), .periph_dout(periph_dout), .analog_en(analog_en),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_drv(pad_drv), .pad_slew(pad_slew)
  );

  // R6: select bit -> pin index
  function automatic logic [15:0] gang_mask(input logic [7:0] c);
    logic [15:0] m = '0;
    if (c[0]) begin
      m[0] = 1'b1;
      if (c[1]) m[1]  = 1'b1;
      if (c[2]) m[2]  = 1'b1;
      if (c[3]) m[3]  = 1'b1;
      if (c[4]) m[10] = 1'b1;
      if (c[5]) m[11] = 1'b1;
      if (c[6]) m[12] = 1'b1;
      if (c[7]) m[13] = 1'b1;
    end
    return m;
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    port_dir = v.dir; port_dout = v.dout; port_drv = v.drv; port_slew = v.slew;
    periph_en = v.pen; periph_oe = v.poe; periph_dout = v.pdo; analog_en = v.ana;
  endtask

  // independent per-pin model of R4 R5 R7 R8 R9 R10 R11
  task automatic check_pins(input string req, input vec_t v);
    logic [15:0] g, e_oe, e_do, e_dr, e_sl;
    g = gang_mask(v.cfg);
    for (int i = 0; i < 16; i++) begin
      if (v.ana[i]) begin
        e_oe[i] = 0; e_do[i] = 0; e_dr[i] = 0; e_sl[i] = 0;
      end else if (g[i]) begin
        e_oe[i] = 1; e_do[i] = v.dout[0]; e_dr[i] = v.drv[0]; e_sl[i] = v.slew[0];
      end else begin
        e_oe[i] = v.pen[i] ? v.poe[i] : v.dir[i];
        e_do[i] = v.pen[i] ? v.pdo[i] : v.dout[i];
        e_dr[i] = v.drv[i];
        e_sl[i] = v.slew[i];
      end
    end
    #1;
    check(req, "pad_oe", pad_oe, e_oe);
    check(req, "pad_do", pad_do, e_do);
    check(req, "pad_drv", pad_drv, e_dr);
    check(req, "pad_slew", pad_slew, e_sl);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    vec_t v;
    do_reset();
    // R1: reset value, no member
    check("R1", "cfg_rdata", {8'h00, cfg_rdata}, 16'h0000);
    v = '{8'h00, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
    apply(v);
    check_pins("R1", v);

    // R2 then R3: second write ignored
    write_cfg(8'h0B);
    check("R2", "cfg_rdata", {8'h00, cfg_rdata}, 16'h000B);
    write_cfg(8'hF0);
    check("R3", "cfg_rdata after 2nd write", {8'h00, cfg_rdata}, 16'h000B);
    write_cfg(8'h00);
    check("R3", "cfg_rdata after 3rd write", {8'h00, cfg_rdata}, 16'h000B);
    v.cfg = 8'h0B;
    apply(v);
    check_pins("R3", v);

    // R3: reset re-arms one write
    do_reset();
    check("R3", "cfg_rdata after reset", {8'h00, cfg_rdata}, 16'h0000);
    write_cfg(8'h81);
    check("R3", "cfg_rdata rewrite", {8'h00, cfg_rdata}, 16'h0081);

    // vector table
    for (int n = 0; n < NVEC; n++) begin
      do_reset();
      write_cfg(VECS[n].cfg);
      check("R2", "table cfg", {8'h00, cfg_rdata}, {8'h00, VECS[n].cfg});
      apply(VECS[n]);
      check_pins("R7", VECS[n]);
    end

    // R6 R4 R5: every register value
    for (int c = 0; c < 256; c++) begin
      do_reset();
      write_cfg(c[7:0]);
      v = '{c[7:0], 16'h0000, 16'h5A5B, 16'hC3C3, 16'h3C3C, 16'h2020, 16'h2020, 16'h0000, 16'h4000};
      apply(v);
      check_pins("R6", v);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule